// File: doc/BRIEF.md
# Two-Frame Slip Buffer with E1/T1 Read Framing

This block decouples a 2.048 Mbit/s line-side bit stream from a system-side bit stream. Bits are stored in two frames of 256 bits each. The write side presents one bit per write strobe, with a marker on the first bit of each line frame. The read side takes one bit per read strobe. It can lay the data out as a 256-bit frame. It can also lay it out as a 193-bit frame that carries 24 channels plus a leading framing bit. A system frame-sync input restarts the read frame at any time.

Both sides run on one fast clock and advance on their own strobes, so the line rate and the system rate may differ by any ratio. Whenever a read frame begins, the block checks how far the write position is ahead of it. If the two positions are about to meet, the block does a controlled slip of one whole frame. A read side that is too fast repeats a frame. A write side that is too fast has one frame dropped. Each slip is recorded in a sticky flag. A rising edge on the align input moves the read position so that it is at least half a frame away from the write position in both directions.

Top module: `es_slip_buffer`

## Requirements
- R1: During and right after reset, rd_bit_o, slip_o and slip_del_o are 0 and both positions sit at bit 0 of frame 0.
- R2: Each write strobe stores wr_bit_i at the next bit position of the current write frame. A write strobe with wr_fs_i high stores at position 0. After position 255 the write side moves to the other frame. The storage address is frame*256 + position.
- R3: In 256-bit mode each read strobe delivers the next stored bit on rd_bit_o one clock later. A read strobe with rd_fs_i high reads position 0. The frame wraps after position 255. Between read strobes, rd_bit_o holds its value.
- R4: With mode_t1_i high the read frame has 193 positions, and position 0 outputs a 1 without reading storage.
- R5: In 193-bit mode, position p >= 1 reads output channel k = (p-1)/8, bit (p-1)%8, taken from 256-bit frame timeslot k + k/3 + 1. Timeslots 0, 4, 8, ..., 28 are never output, and bit 0 of a timeslot (the first one written, the MSB) goes out first.
- R6: Whenever a read frame starts (a read strobe at position 0), d = (write-next address - start address of the other frame) mod 512. If d < 32, the same frame is read again: slip_o goes to 1 and slip_del_o to 0.
- R7: If d >= 480 at that point, the other frame is skipped and the same frame is read: slip_o goes to 1 and slip_del_o to 1. Otherwise the read moves to the other frame and the flags do not change.
- R8: slip_o stays 1 until an align rising edge. slip_del_o always shows the type of the most recent slip.
- R9: On an align rising edge, the read frame is chosen so that (write-next address - read address) mod 512 lies in [128, 383]. Both flags clear, and no slip decision is taken in that clock.
- R10: Holding align_i high has no further effect. A new realign needs align_i to go low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Common clock for both sides |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_t1_i | input | 1 | 1 selects the 193-bit read framing |
| align_i | input | 1 | Realign control, acts on its rising edge |
| wr_vld_i | input | 1 | Write strobe |
| wr_fs_i | input | 1 | Marks the first bit of a line frame |
| wr_bit_i | input | 1 | Line data bit |
| rd_vld_i | input | 1 | Read strobe |
| rd_fs_i | input | 1 | System frame sync, restarts the read frame |
| rd_bit_o | output | 1 | System data bit |
| slip_o | output | 1 | Sticky slip flag |
| slip_del_o | output | 1 | Last slip dropped a frame (1) or repeated one (0) |

## Verification
The bench runs the read strobe both faster and slower than the write strobe, so that the repeat and the drop windows are both entered. A design that mixed up the two windows, or used the wrong frame in either one, would show a wrong data stream and a wrong slip_del_o. Realign is driven while align_i is held high and a slip occurs during the hold. A design that acted on the level rather than the edge would clear the flag again. The 193-bit mode runs at an exactly matched rate with random data, so a dropped timeslot that was mapped wrongly, or a missing forced framing bit, shows up as a mismatch. Frame-start markers arrive in the middle of a frame on both sides, to check that both sides restart at position 0.

// File: rtl/es_pkg.sv
package es_pkg;
  typedef enum logic [1:0] {
    SLIP_NONE   = 2'd0,
    SLIP_REPEAT = 2'd1,
    SLIP_DELETE = 2'd2
  } slip_e;
endpackage

// File: rtl/es_wr_ctrl.sv
module es_wr_ctrl #(
  parameter int unsigned FRAME_BITS = 256,
  localparam int unsigned BW = $clog2(FRAME_BITS),
  localparam int unsigned AW = BW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_vld_i,
  input  logic          wr_fs_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] wnext_o
);
  logic          fsel_q;
  logic [BW-1:0] bcnt_q;
  logic [BW-1:0] bit_idx;

  assign bit_idx = wr_fs_i ? '0 : bcnt_q;
  assign we_o    = wr_vld_i;
  assign waddr_o = {fsel_q, bit_idx};
  assign wnext_o = {fsel_q, bcnt_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsel_q <= 1'b0;
      bcnt_q <= '0;
    end else if (wr_vld_i) begin
      if (bit_idx == BW'(FRAME_BITS - 1)) begin
        bcnt_q <= '0;
        fsel_q <= ~fsel_q;
      end else begin
        bcnt_q <= bit_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/es_mem.sv
module es_mem #(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic          wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic          rdata_o
);
  logic [DEPTH-1:0] mem_q;

  // read returns the value held before a same-cycle write
  assign rdata_o = mem_q[raddr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mem_q <= '0;
    else if (we_i) mem_q[waddr_i] <= wdata_i;
  end
endmodule

// File: rtl/es_rd_map.sv
module es_rd_map #(
  parameter int unsigned CH_BITS = 8,
  parameter int unsigned E1_CH   = 32,
  parameter int unsigned T1_CH   = 24,
  localparam int unsigned FRAME_BITS = CH_BITS * E1_CH,
  localparam int unsigned BW   = $clog2(FRAME_BITS),
  localparam int unsigned KEEP = T1_CH / (E1_CH - T1_CH)
) (
  input  logic [BW-1:0] pos_i,
  input  logic          t1_i,
  output logic [BW-1:0] ebit_o,
  output logic          fbit_o
);
  always_comb begin
    int unsigned q;
    int unsigned k;
    int unsigned b;
    int unsigned ts;
    q = 0;
    k = 0;
    b = 0;
    ts = 0;
    fbit_o = 1'b0;
    ebit_o = pos_i;
    if (t1_i) begin
      if (pos_i == '0) begin
        fbit_o = 1'b1;
        ebit_o = '0;
      end else begin
        q  = 32'(pos_i) - 1;
        k  = q / CH_BITS;
        b  = q % CH_BITS;
        ts = k + k / KEEP + 1;
        ebit_o = BW'(ts * CH_BITS + b);
      end
    end
  end
endmodule

// File: rtl/es_rd_ctrl.sv
module es_rd_ctrl
  import es_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 256,
  parameter int unsigned T1_LAST    = 192,
  parameter int unsigned SLIP_GUARD = 32,
  localparam int unsigned BW   = $clog2(FRAME_BITS),
  localparam int unsigned AW   = BW + 1,
  localparam int unsigned HALF = FRAME_BITS / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_vld_i,
  input  logic          rd_fs_i,
  input  logic          t1_i,
  input  logic          align_i,
  input  logic [AW-1:0] wnext_i,
  input  logic [BW-1:0] ebit_i,
  input  logic          fbit_i,
  input  logic          rdata_i,
  output logic [BW-1:0] pos_o,
  output logic [AW-1:0] raddr_o,
  output logic          rd_bit_o,
  output logic          slip_o,
  output logic          slip_del_o
);
  logic          rf_q, rf_n, align_q, rise, start, in_win;
  logic [BW-1:0] rcnt_q, last;
  logic [AW-1:0] d_win, d_cand;
  slip_e         kind;

  assign pos_o  = (rd_vld_i && rd_fs_i) ? '0 : rcnt_q;
  assign rise   = align_i & ~align_q;
  assign start  = rd_vld_i && (pos_o == '0);
  assign d_win  = wnext_i - {rf_q, ebit_i};
  assign d_cand = wnext_i - {~rf_q, {BW{1'b0}}};
  assign in_win = (d_win >= AW'(HALF)) && (d_win < AW'(FRAME_BITS + HALF));
  assign last   = t1_i ? BW'(T1_LAST) : BW'(FRAME_BITS - 1);

  always_comb begin
    if (d_cand < AW'(SLIP_GUARD))                       kind = SLIP_REPEAT;
    else if (d_cand >= AW'(2 * FRAME_BITS - SLIP_GUARD)) kind = SLIP_DELETE;
    else                                                kind = SLIP_NONE;
  end

  // realign overrides the frame-start decision
  always_comb begin
    rf_n = rf_q;
    if (rise) begin
      if (!in_win) rf_n = ~rf_q;
    end else if (start && kind == SLIP_NONE) begin
      rf_n = ~rf_q;
    end
  end

  assign raddr_o = {rf_n, ebit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rf_q       <= 1'b0;
      align_q    <= 1'b0;
      rcnt_q     <= '0;
      rd_bit_o   <= 1'b0;
      slip_o     <= 1'b0;
      slip_del_o <= 1'b0;
    end else begin
      align_q <= align_i;
      rf_q    <= rf_n;
      if (rd_vld_i) begin
        rd_bit_o <= fbit_i ? 1'b1 : rdata_i;
        rcnt_q   <= (pos_o >= last) ? '0 : pos_o + 1'b1;
      end
      if (rise) begin
        slip_o     <= 1'b0;
        slip_del_o <= 1'b0;
      end else if (start && kind != SLIP_NONE) begin
        slip_o     <= 1'b1;
        slip_del_o <= (kind == SLIP_DELETE);
      end
    end
  end
endmodule

// File: rtl/es_slip_buffer.sv
module es_slip_buffer #(
  parameter int unsigned CH_BITS    = 8,
  parameter int unsigned E1_CH      = 32,
  parameter int unsigned T1_CH      = 24,
  parameter int unsigned SLIP_GUARD = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_t1_i,
  input  logic align_i,
  input  logic wr_vld_i,
  input  logic wr_fs_i,
  input  logic wr_bit_i,
  input  logic rd_vld_i,
  input  logic rd_fs_i,
  output logic rd_bit_o,
  output logic slip_o,
  output logic slip_del_o
);
  localparam int unsigned FRAME_BITS = CH_BITS * E1_CH;
  localparam int unsigned BW         = $clog2(FRAME_BITS);
  localparam int unsigned AW         = BW + 1;
  localparam int unsigned DEPTH      = 2 * FRAME_BITS;
  localparam int unsigned T1_LAST    = T1_CH * CH_BITS;

  logic          we, rdata, fbit;
  logic [AW-1:0] waddr, wr_next, raddr;
  logic [BW-1:0] rd_pos, ebit;

  es_wr_ctrl #(.FRAME_BITS(FRAME_BITS)) u_wr (
    .clk_i, .rst_ni, .wr_vld_i, .wr_fs_i,
    .we_o(we), .waddr_o(waddr), .wnext_o(wr_next)
  );

  es_mem #(.DEPTH(DEPTH)) u_mem (
    .clk_i, .rst_ni, .we_i(we), .waddr_i(waddr), .wdata_i(wr_bit_i),
    .raddr_i(raddr), .rdata_o(rdata)
  );

  es_rd_map #(.CH_BITS(CH_BITS), .E1_CH(E1_CH), .T1_CH(T1_CH)) u_map (
    .pos_i(rd_pos), .t1_i(mode_t1_i), .ebit_o(ebit), .fbit_o(fbit)
  );

  es_rd_ctrl #(
    .FRAME_BITS(FRAME_BITS), .T1_LAST(T1_LAST), .SLIP_GUARD(SLIP_GUARD)
  ) u_rd (
    .clk_i, .rst_ni, .rd_vld_i, .rd_fs_i, .t1_i(mode_t1_i), .align_i,
    .wnext_i(wr_next), .ebit_i(ebit), .fbit_i(fbit), .rdata_i(rdata),
    .pos_o(rd_pos), .raddr_o(raddr), .rd_bit_o, .slip_o, .slip_del_o
  );
endmodule

// File: rtl/es_slip_buffer_chk.sv
module es_slip_buffer_chk #(
  parameter int unsigned BW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mode_t1_i,
  input logic          align_i,
  input logic          wr_vld_i,
  input logic          wr_fs_i,
  input logic          rd_vld_i,
  input logic          rd_bit_o,
  input logic          slip_o,
  input logic [BW-1:0] rd_pos,
  input logic [BW:0]   wr_next
);
  logic prev_align;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_align <= 1'b0;
    else         prev_align <= align_i;
  end

  a_r2_fs_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vld_i && wr_fs_i |=> wr_next[BW-1:0] == BW'(1));

  a_r3_hold_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_vld_i |=> $stable(rd_bit_o));

  a_r4_fbit_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_i && mode_t1_i && rd_pos == '0 |=> rd_bit_o);

  a_r6_slip_only_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_vld_i && rd_pos == '0) && !slip_o |=> !slip_o);

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_o && !(align_i && !prev_align) |=> slip_o);
endmodule

bind es_slip_buffer es_slip_buffer_chk #(.BW(BW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_t1_i(mode_t1_i), .align_i(align_i),
  .wr_vld_i(wr_vld_i), .wr_fs_i(wr_fs_i), .rd_vld_i(rd_vld_i),
  .rd_bit_o(rd_bit_o), .slip_o(slip_o), .rd_pos(rd_pos), .wr_next(wr_next)
);

// File: tb/es_slip_buffer_tb.sv
module es_slip_buffer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_t1 = 1'b0, align = 1'b0;
  logic wr_vld = 1'b0, wr_fs = 1'b0, wr_bit = 1'b0;
  logic rd_vld = 1'b0, rd_fs = 1'b0;
  logic rd_bit, slip, slip_del;

  int checks = 0, failures = 0, cyc = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;

  es_slip_buffer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_t1_i(mode_t1), .align_i(align),
    .wr_vld_i(wr_vld), .wr_fs_i(wr_fs), .wr_bit_i(wr_bit),
    .rd_vld_i(rd_vld), .rd_fs_i(rd_fs),
    .rd_bit_o(rd_bit), .slip_o(slip), .slip_del_o(slip_del)
  );

  // behavioural reference
  int mmem[512];
  int m_wf, m_wcnt, m_rf, m_rcnt, m_aq, m_out, m_slip, m_sdel;

  function automatic int t1_addr(int p);
    int q = p - 1;
    int k = q / 8;
    return (k + k / 3 + 1) * 8 + q % 8;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mmem[i]) mmem[i] = 0;
      m_wf = 0; m_wcnt = 0; m_rf = 0; m_rcnt = 0;
      m_aq = 0; m_out = 0; m_slip = 0; m_sdel = 0;
    end else begin
      int p, eb, wn, d, fl, wb;
      p  = (rd_vld && rd_fs) ? 0 : m_rcnt;
      eb = mode_t1 ? ((p == 0) ? 0 : t1_addr(p)) : p;
      wn = m_wf * 256 + m_wcnt;
      fl = mode_t1 ? 193 : 256;
      if (align && !m_aq) begin
        d = (wn - (m_rf * 256 + eb) + 1024) % 512;
        if (!(d >= 128 && d < 384)) m_rf = 1 - m_rf;
        m_slip = 0; m_sdel = 0;
      end else if (rd_vld && p == 0) begin
        d = (wn - (1 - m_rf) * 256 + 1024) % 512;
        if (d < 32) begin m_slip = 1; m_sdel = 0; end
        else if (d >= 480) begin m_slip = 1; m_sdel = 1; end
        else m_rf = 1 - m_rf;
      end
      if (rd_vld) begin
        m_out  = (mode_t1 && p == 0) ? 1 : mmem[m_rf * 256 + eb];
        m_rcnt = (p >= fl - 1) ? 0 : p + 1;
      end
      if (wr_vld) begin
        wb = wr_fs ? 0 : m_wcnt;
        mmem[m_wf * 256 + wb] = int'(wr_bit);
        if (wb == 255) begin m_wf = 1 - m_wf; m_wcnt = 0; end
        else m_wcnt = wb + 1;
      end
      m_aq = int'(align);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (int'(rd_bit) != m_out || int'(slip) != m_slip || int'(slip_del) != m_sdel) begin
        failures++;
        $display("FAIL %s cycle %0d: rd_bit/slip/slip_del actual=%0b%0b%0b expected=%0d%0d%0d",
                 cur_req, cyc, rd_bit, slip, slip_del, m_out, m_slip, m_sdel);
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
      finish_run();
    end
  end

  // stimulus framing state
  int wpos = 0, rpos = 0, acc_w = 0, acc_r = 0;
  bit inj_w = 1'b0, inj_r = 1'b0;

  task automatic run(int n, int wrate, int rrate);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      acc_w += wrate;
      acc_r += rrate;
      wr_vld = (acc_w >= 256);
      rd_vld = (acc_r >= 256);
      if (wr_vld) acc_w -= 256;
      if (rd_vld) acc_r -= 256;
      wr_fs = 1'b0;
      rd_fs = 1'b0;
      if (wr_vld) begin
        if (inj_w) begin wpos = 0; inj_w = 1'b0; end
        wr_fs  = (wpos == 0);
        wr_bit = 1'($urandom);
        wpos   = (wpos + 1) % 256;
      end
      if (rd_vld) begin
        if (inj_r) begin rpos = 0; inj_r = 1'b0; end
        rd_fs = (rpos == 0);
        rpos  = (rpos + 1) % (mode_t1 ? 193 : 256);
      end
    end
    @(negedge clk);
    wr_vld = 1'b0; rd_vld = 1'b0; wr_fs = 1'b0; rd_fs = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1", "rd_bit_o in reset", int'(rd_bit), 0);
    chk("R1", "slip_o in reset", int'(slip), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "slip_del_o after reset", int'(slip_del), 0);

    cur_req = "R3";           // matched rates, 256-bit framing
    run(1000, 256, 256);
    chk("R7", "slip_o with matched rates", int'(slip), 0);
    run(20, 0, 0);            // idle: output holds

    cur_req = "R2";           // mid-frame write marker, slow read
    inj_w = 1'b1;
    run(600, 256, 224);
    cur_req = "R3";           // mid-frame read sync
    inj_r = 1'b1;
    run(1900, 256, 224);
    chk("R7", "slip_o after slow read", int'(slip), 1);
    chk("R7", "slip_del_o after slow read", int'(slip_del), 1);

    cur_req = "R9";
    align = 1'b1;
    run(1, 256, 224);
    chk("R9", "slip_o after realign", int'(slip), 0);
    chk("R9", "slip_del_o after realign", int'(slip_del), 0);
    cur_req = "R10";          // align held high, drops still flagged
    run(2500, 256, 224);
    chk("R10", "slip_o with align held", int'(slip), 1);
    align = 1'b0;

    cur_req = "R6";           // fast read
    run(4000, 224, 256);
    chk("R6", "slip_o after fast read", int'(slip), 1);
    chk("R6", "slip_del_o after fast read", int'(slip_del), 0);
    cur_req = "R8";
    run(1000, 256, 256);
    chk("R8", "slip_o stays set", int'(slip), 1);

    cur_req = "R4";           // 193-bit framing at matched frame rate
    mode_t1 = 1'b1;
    inj_r = 1'b1;
    align = 1'b1;
    run(1500, 256, 193);
    chk("R9", "slip_o cleared by second rising edge", int'(slip), 0);
    cur_req = "R5";
    run(2500, 256, 193);
    chk("R5", "no slip at matched frame rate", int'(slip), 0);
    align = 1'b0;

    finish_run();
  end
endmodule